// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is a 32-pin general-purpose I/O port controlled through a small synchronous register bus. Each pin has four control bits. A direction bit turns the output driver on or off. A level bit sets the static value the pin drives. A blink bit makes a driven pin toggle in hardware instead of holding a level. An inversion bit flips how the sampled input appears to software.

Pad inputs pass through a two-stage synchronizer. They are then XORed with the inversion bits and presented in a read-only data-in register. Blinking pins all follow one shared square wave. A programmable period counter sets its rate, so every blinking pin switches on the same clock edge. Software writes whole 32-bit words. Reads return a result one cycle after the read strobe. Interrupt logic lives in a separate block that can consume the corrected data-in value.

Top module: `gpio_port_bank`

## Requirements
- R1: Reset state: the direction register reads all ones (all pins are inputs). The level, blink and inversion registers read zero. The period register reads the RESET_PERIOD parameter. pad_oe is all zero, both during reset and right after it.
- R2: For each pin, pad_oe is 1 exactly when that pin's direction bit is 0. A 1 in the direction register means input; a 0 means output.
- R3: For each pin whose blink bit is 0, pad_out equals that pin's bit in the level register.
- R4: The data-in register (address 4) returns the synchronized pad level XOR the inversion register. A change on pad_in first shows in a read captured on the third rising edge after the change. The two earlier captures still show the old value.
- R5: Setting an inversion bit inverts only that pin's bit in data-in. Pins with a clear inversion bit read the true pad level.
- R6: Register addresses are: direction 0, level 1, blink 2, inversion 3, data-in 4, period 5. A write replaces the whole word. A read returns the register contents on bus_rdata one cycle after bus_rd. bus_rdata holds its value while no read is issued.
- R7: For pins with the blink bit set, pad_out follows a shared phase bit. The phase toggles every period+1 clock cycles, where period is the period register value.
- R8: All pins with the blink bit set show the same pad_out value in every cycle.
- R9: A write to data-in (address 4) changes no register. Reads of the unused addresses 6 and 7 return zero.
- R10: The period register is PERIOD_W (16) bits wide. Write data above bit 15 is dropped, and reads return the value zero-extended. A write to the period register restarts the period counter at zero and sets the phase low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd |
| pad_in | input | 32 | Raw pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables, active high |

## Verification
Some properties are checked on every cycle by the assertions:
- the period counter never passes its limit;
- the phase changes exactly on the counter's terminal count and otherwise holds;
- blinking pins never disagree with one another;
- a write to data-in leaves the control registers unchanged;
- the read result holds between reads.

Other behaviour can only be shown by the bench's scenarios:
- the exact toggle period;
- the three-edge input latency;
- inversion per pin;
- register readback;
- the reset values, including after a reset applied mid-run.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int ADDR_W = 3;

    // Register word addresses on the control bus
    localparam logic [ADDR_W-1:0] REG_DIR    = 3'd0;
    localparam logic [ADDR_W-1:0] REG_LEVEL  = 3'd1;
    localparam logic [ADDR_W-1:0] REG_BLINK  = 3'd2;
    localparam logic [ADDR_W-1:0] REG_INVERT = 3'd3;
    localparam logic [ADDR_W-1:0] REG_DIN    = 3'd4;
    localparam logic [ADDR_W-1:0] REG_PERIOD = 3'd5;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.s2;

endmodule

// File: rtl/gpio_blink_timer.sv
module gpio_blink_timer #(
    parameter int              PERIOD_W     = 16,
    parameter logic [PERIOD_W-1:0] RESET_PERIOD = 16'd4999
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                period_we,
    input  logic [PERIOD_W-1:0] period_wdata,
    output logic [PERIOD_W-1:0] period_q,
    output logic                phase
);

    typedef struct packed {
        logic [PERIOD_W-1:0] lim;
        logic [PERIOD_W-1:0] cnt;
        logic                phase;
    } tmr_t;

    tmr_t st_d, st_q;
    logic tick;

    assign tick = (st_q.cnt == st_q.lim);

    always_comb begin
        st_d = st_q;
        if (period_we) begin
            st_d.lim   = period_wdata;
            st_d.cnt   = '0;
            st_d.phase = 1'b0;
        end else if (tick) begin
            st_d.cnt   = '0;
            st_d.phase = ~st_q.phase;
        end else begin
            st_d.cnt   = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lim   <= RESET_PERIOD;
            st_q.cnt   <= '0;
            st_q.phase <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign period_q = st_q.lim;
    assign phase    = st_q.phase;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.lim); // R7

    AST_PHASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tick) && !$past(period_we)) |-> (st_q.phase != $past(st_q.phase))); // R7

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tick) && !$past(period_we)) |-> $stable(st_q.phase)); // R7

    AST_PERIOD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        period_we |=> (st_q.cnt == '0 && !st_q.phase)); // R10

endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_pkg::*;
#(
    parameter int N        = 32,
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [N-1:0]        wdata,
    input  logic [N-1:0]        din_live,
    input  logic [PERIOD_W-1:0] period_q,
    output logic [N-1:0]        rd_data,
    output logic [N-1:0]        dir,
    output logic [N-1:0]        level,
    output logic [N-1:0]        blink,
    output logic [N-1:0]        invert,
    output logic                period_we,
    output logic [PERIOD_W-1:0] period_wdata
);

    typedef struct packed {
        logic [N-1:0] dir;
        logic [N-1:0] level;
        logic [N-1:0] blink;
        logic [N-1:0] invert;
        logic [N-1:0] rdata;
    } regs_t;

    regs_t st_d, st_q;
    logic [N-1:0] rd_mux;

    always_comb begin
        case (addr)
            REG_DIR:    rd_mux = st_q.dir;
            REG_LEVEL:  rd_mux = st_q.level;
            REG_BLINK:  rd_mux = st_q.blink;
            REG_INVERT: rd_mux = st_q.invert;
            REG_DIN:    rd_mux = din_live;
            REG_PERIOD: rd_mux = N'(period_q);
            default:    rd_mux = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (addr)
                REG_DIR:    st_d.dir    = wdata;
                REG_LEVEL:  st_d.level  = wdata;
                REG_BLINK:  st_d.blink  = wdata;
                REG_INVERT: st_d.invert = wdata;
                default:    ;
            endcase
        end
        if (rd_en) begin
            st_d.rdata = rd_mux;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dir    <= '1;
            st_q.level  <= '0;
            st_q.blink  <= '0;
            st_q.invert <= '0;
            st_q.rdata  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign period_we    = wr_en && (addr == REG_PERIOD);
    assign period_wdata = wdata[PERIOD_W-1:0];
    assign rd_data      = st_q.rdata;
    assign dir          = st_q.dir;
    assign level        = st_q.level;
    assign blink        = st_q.blink;
    assign invert       = st_q.invert;

    AST_DIN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_DIN) |=> ($stable(st_q.dir) && $stable(st_q.level)
                                        && $stable(st_q.blink) && $stable(st_q.invert))); // R9

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R6

endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
    import gpio_pkg::*;
#(
    parameter int                  NPINS        = 32,
    parameter int                  PERIOD_W     = 16,
    parameter logic [PERIOD_W-1:0] RESET_PERIOD = 16'd4999
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);

    logic [NPINS-1:0]    pad_sync;
    logic [NPINS-1:0]    din_live;
    logic [NPINS-1:0]    dir, level, blink, invert;
    logic                period_we;
    logic [PERIOD_W-1:0] period_wdata;
    logic [PERIOD_W-1:0] period_q;
    logic                phase;

    gpio_in_sync #(.N(NPINS)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pad_sync)
    );

    assign din_live = pad_sync ^ invert;

    gpio_ctrl_regs #(.N(NPINS), .PERIOD_W(PERIOD_W)) i_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (bus_wr),
        .rd_en        (bus_rd),
        .addr         (bus_addr),
        .wdata        (bus_wdata),
        .din_live     (din_live),
        .period_q     (period_q),
        .rd_data      (bus_rdata),
        .dir          (dir),
        .level        (level),
        .blink        (blink),
        .invert       (invert),
        .period_we    (period_we),
        .period_wdata (period_wdata)
    );

    gpio_blink_timer #(.PERIOD_W(PERIOD_W), .RESET_PERIOD(RESET_PERIOD)) i_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_we    (period_we),
        .period_wdata (period_wdata),
        .period_q     (period_q),
        .phase        (phase)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign pad_out[i] = blink[i] ? phase : level[i];
        assign pad_oe[i]  = ~dir[i];
    end

    AST_BLINK_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & blink) == '0) || ((pad_out & blink) == blink)); // R8

    AST_OE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pad_oe == '0)); // R1

endmodule

// File: tb/test_gpio_port_bank.sv
module test_gpio_port_bank;
    import gpio_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    gpio_port_bank i_gpio_port_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    typedef struct packed {
        logic        wr;
        logic [2:0]  addr;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VEC [0:NVEC-1] = '{
        '{1'b1, 3'd0, 32'hFFFF_0000, 8'd6},   // R6 write direction
        '{1'b0, 3'd0, 32'hFFFF_0000, 8'd6},   // R6 read direction
        '{1'b1, 3'd1, 32'hA5A5_5A5A, 8'd6},   // R6 write level
        '{1'b0, 3'd1, 32'hA5A5_5A5A, 8'd6},   // R6
        '{1'b1, 3'd2, 32'h00F0_000F, 8'd6},   // R6 write blink
        '{1'b0, 3'd2, 32'h00F0_000F, 8'd6},   // R6
        '{1'b1, 3'd3, 32'h1234_5678, 8'd6},   // R6 write inversion
        '{1'b0, 3'd3, 32'h1234_5678, 8'd6},   // R6
        '{1'b1, 3'd4, 32'hDEAD_BEEF, 8'd9},   // R9 write to data-in
        '{1'b0, 3'd0, 32'hFFFF_0000, 8'd9},   // R9 direction untouched
        '{1'b0, 3'd1, 32'hA5A5_5A5A, 8'd9},   // R9 level untouched
        '{1'b0, 3'd6, 32'h0000_0000, 8'd9},   // R9 unused address
        '{1'b0, 3'd7, 32'h0000_0000, 8'd9},   // R9 unused address
        '{1'b1, 3'd5, 32'hFFFF_0009, 8'd10},  // R10 wide write
        '{1'b0, 3'd5, 32'h0000_0009, 8'd10}   // R10 upper bits dropped
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd   = 1'b1;
        bus_addr = a;
        @(negedge clk);
        d      = bus_rdata;
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [31:0] exp_pad;

        // R1: state held in reset
        repeat (3) @(negedge clk);
        check("R1 oe in reset", pad_oe, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 oe after reset", pad_oe, 32'h0);
        bus_read(REG_DIR, r);    check("R1 direction", r, 32'hFFFF_FFFF);
        bus_read(REG_LEVEL, r);  check("R1 level", r, 32'h0);
        bus_read(REG_BLINK, r);  check("R1 blink", r, 32'h0);
        bus_read(REG_INVERT, r); check("R1 inversion", r, 32'h0);
        bus_read(REG_PERIOD, r); check("R1 period", r, 32'd4999);

        // Vector table: register writes and readback
        for (int k = 0; k < NVEC; k++) begin
            if (VEC[k].wr) begin
                bus_write(VEC[k].addr, VEC[k].data);
            end else begin
                bus_read(VEC[k].addr, r);
                check($sformatf("R%0d vector %0d", VEC[k].req, k), r, VEC[k].data);
            end
        end

        // R2 and R3: direction and static level
        bus_write(REG_BLINK, 32'h0);
        bus_write(REG_DIR, 32'hFFFF_00FF);
        bus_write(REG_LEVEL, 32'h0000_3C00);
        @(negedge clk);
        check("R2 output enables", pad_oe, 32'h0000_FF00);
        check("R3 static level", pad_out, 32'h0000_3C00);

        // R4 and R5: data-in path
        bus_write(REG_INVERT, 32'h0);
        pad_in = 32'h1357_9BDF;
        repeat (4) @(negedge clk);
        bus_read(REG_DIN, r);
        check("R4 data-in true level", r, 32'h1357_9BDF);
        bus_write(REG_INVERT, 32'hFFFF_0000);
        bus_read(REG_DIN, r);
        check("R5 inversion upper half", r, 32'h1357_9BDF ^ 32'hFFFF_0000);
        bus_write(REG_INVERT, 32'h0000_0001);
        bus_read(REG_DIN, r);
        check("R5 inversion pin 0", r, 32'h1357_9BDE);

        // R4: three-edge latency
        bus_write(REG_INVERT, 32'h0);
        @(negedge clk);
        pad_in   = 32'hCAFE_0F0F;
        bus_rd   = 1'b1;
        bus_addr = REG_DIN;
        @(negedge clk);
        check("R4 latency edge 1", bus_rdata, 32'h1357_9BDF);
        @(negedge clk);
        check("R4 latency edge 2", bus_rdata, 32'h1357_9BDF);
        @(negedge clk);
        check("R4 latency edge 3", bus_rdata, 32'hCAFE_0F0F);
        bus_rd = 1'b0;

        // R7, R8, R10: blink timing with period 3
        bus_write(REG_DIR, 32'hFFFF_FF00);
        bus_write(REG_LEVEL, 32'h0000_0004);
        bus_write(REG_BLINK, 32'h0000_0021);
        bus_write(REG_PERIOD, 32'h0000_0003);
        check("R10 restart phase low", pad_out & 32'h27, 32'h0000_0004);
        for (int n = 1; n <= 20; n++) begin
            @(negedge clk);
            exp_pad = (((n / 4) % 2) == 1) ? 32'h0000_0025 : 32'h0000_0004;
            check($sformatf("R7 R8 blink cycle %0d", n), pad_out & 32'h27, exp_pad);
        end

        // R9: data-in write leaves pads unchanged
        bus_write(REG_BLINK, 32'h0);
        bus_write(REG_DIN, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R9 pads after data-in write", pad_out, 32'h0000_0004);
        check("R9 enables after data-in write", pad_oe, 32'h0000_00FF);
        check("R3 level after blink off", pad_out & 32'h21, 32'h0);

        // R1: reset applied mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 oe on mid-run reset", pad_oe, 32'h0);
        check("R1 out on mid-run reset", pad_out, 32'h0);
        rst_n = 1'b1;
        bus_read(REG_DIR, r);    check("R1 direction after re-reset", r, 32'hFFFF_FFFF);
        bus_read(REG_PERIOD, r); check("R1 period after re-reset", r, 32'd4999);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule